// File: doc/BRIEF.md
# Protected Array Control Register Bank

This block is the small register bank that sits beside an 8K x 8 serial static memory. A byte-wide register bus reaches a control byte, an eight-byte serial number that the host may program, and two read-only identity bytes. From the two protection bits in the control byte, the bank decides for every host write to the main array whether that write may land, and it drives the array's write enable to match.

The control byte also holds a lock bit for the serial number. Once that bit is set it cannot be cleared by a write, and the serial-number bytes then refuse all writes. Two strobes model what happens across a power cycle. A store strobe captures the current lock value into a snapshot output, and the external nonvolatile copy keeps that value. A recall strobe loads the lock from an input, which happens at power-up. A lock set after the last store is therefore lost when power is removed.

The lock is held in a three-state machine. In `LK_OPEN` the lock is clear. A control write with bit 6 set moves it to `LK_HELD`: locked, but not yet captured by a store. A store moves it from `LK_HELD` to `LK_SAVED`. A recall moves any state to `LK_SAVED` when the input is 1, and to `LK_OPEN` when it is 0. No write returns `LK_HELD` or `LK_SAVED` to `LK_OPEN`.

Top module: `pmreg_bank`

## Requirements
- R1: The control byte is at register address 0x00. Bit 6 is the lock, bits 3:2 are the protection level (bit 3 high, bit 2 low), and all other bits read as 0.
- R2: The protection level selects which array addresses block writes. Level 0 blocks none, level 1 blocks 0x1800–0x1FFF, level 2 blocks 0x1000–0x1FFF, and level 3 blocks 0x0000–0x1FFF. The write enable equals the write request outside the blocked range and is 0 inside it.
- R3: After reset, the control byte, the serial bytes and the snapshot output are all 0.
- R4: Once the lock is 1, writing 0 to bit 6 of the control byte leaves it at 1. The protection bits are still written.
- R5: Register addresses 0x01–0x08 hold serial-number bytes 0–7. They can be written while the lock is 0, and they keep their value through writes while the lock is 1.
- R6: Address 0x09 reads the high identity byte and 0x0A reads the low identity byte (default 0xC3 and 0x5A). Writes to these addresses have no effect.
- R7: Reserved addresses 0x0B–0x0D and every other unmapped address read 0x00. Writes to them change no readable register.
- R8: A store strobe updates the snapshot output one cycle later with the lock value from before the edge. The store works at every protection level, so a lock set after the last store is absent from the snapshot.
- R9: A recall strobe sets the lock to the recall input one cycle later. Recall takes priority over a store or a lock write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational from the address) |
| arr_addr | input | 13 | Main array address of the host write |
| arr_wr_req | input | 1 | Host write request to the array |
| arr_wr_en | output | 1 | Gated array write enable |
| nv_store | input | 1 | Store strobe: capture the lock into the snapshot |
| nv_recall | input | 1 | Recall strobe: load the lock from nv_lock_in |
| nv_lock_in | input | 1 | Lock value restored on recall |
| nv_lock_snap | output | 1 | Lock value captured by the last store |

## Verification
The assertions check several things on every cycle. Whatever write arrives, a set lock stays set unless a recall comes. Locked serial bytes hold still. The array enable is always off at the full protection level and always follows the request at level zero. The snapshot and the recall each land one cycle after their strobe. Other behaviour can be shown only by the bench's scenarios. These include the exact quarter and half boundaries, the bit layout of the control byte as read back, the identity and reserved read values, and a lock that is lost or kept across a modelled power cycle. In each case the outcome depends on a chosen order of writes, stores and resets.

// File: rtl/pmreg_pkg.sv
`timescale 1ns/1ps
package pmreg_pkg;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'd0,
        PROT_QUARTER = 2'd1,
        PROT_HALF    = 2'd2,
        PROT_ALL     = 2'd3
    } prot_lvl_e;

    typedef enum logic [1:0] {
        LK_OPEN  = 2'd0,
        LK_HELD  = 2'd1,
        LK_SAVED = 2'd2
    } lock_state_e;

    localparam int CTRL_ADDR   = 0;
    localparam int SN_BASE     = 1;
    localparam int LOCK_BIT    = 6;
    localparam int PROT_LO_BIT = 2;

endpackage

// File: rtl/pmreg_prot.sv
`timescale 1ns/1ps
module pmreg_prot
    import pmreg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prot_lvl_e         level,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    output logic              wr_en
);
    localparam int TOP = ADDR_W - 1;

    logic blocked;

    always_comb begin
        blocked = 1'b0;
        unique case (level)
            PROT_NONE:    blocked = 1'b0;
            PROT_QUARTER: blocked = addr[TOP] & addr[TOP-1];
            PROT_HALF:    blocked = addr[TOP];
            PROT_ALL:     blocked = 1'b1;
        endcase
    end

    assign wr_en = wr_req & ~blocked;

    // R2: full protection never lets a write through
    a_r2_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PROT_ALL) |-> !wr_en);
    // R2: no protection passes every request
    a_r2_none_open: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PROT_NONE) |-> (wr_en == wr_req));

endmodule

// File: rtl/pmreg_lock_fsm.sv
`timescale 1ns/1ps
module pmreg_lock_fsm
    import pmreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic store,
    input  logic recall,
    input  logic recall_val,
    output logic lock_o,
    output logic snap_o
);
    lock_state_e state_q, state_d;
    logic        snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:  if (set_req) state_d = LK_HELD;
            LK_HELD:  if (store)   state_d = LK_SAVED;
            LK_SAVED: state_d = LK_SAVED;
            default:  state_d = LK_OPEN;
        endcase
        if (recall) state_d = recall_val ? LK_SAVED : LK_OPEN;
    end

    always_comb begin
        lock_o = (state_q != LK_OPEN);
        snap_o = snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                snap_q <= 1'b0;
        else if (store && !recall) snap_q <= lock_o;
    end

    // R4: a set lock stays set unless a recall arrives
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !recall) |=> lock_o);
    // R8: the snapshot follows the lock one cycle after a store
    a_r8_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !recall) |=> (snap_o == $past(lock_o)));
    // R9: recall loads the lock from its input
    a_r9_recall_load: assert property (@(posedge clk) disable iff (!rst_n)
        recall |=> (lock_o == $past(recall_val)));

endmodule

// File: rtl/pmreg_serial.sv
`timescale 1ns/1ps
module pmreg_serial
    import pmreg_pkg::*;
#(
    parameter int N_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    input  logic                  we,
    input  logic                  locked,
    output logic [N_BYTES-1:0][7:0] bytes_o
);
    logic [N_BYTES-1:0][7:0] sn_q;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        logic hit;
        assign hit = we && !locked && (int'(addr) == SN_BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sn_q[i] <= 8'h00;
            else if (hit) sn_q[i] <= wdata;
        end
    end

    assign bytes_o = sn_q;

    // R5: a locked serial number does not change
    a_r5_sn_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sn_q));

endmodule

// File: rtl/pmreg_bank.sv
`timescale 1ns/1ps
module pmreg_bank
    import pmreg_pkg::*;
#(
    parameter int          ADDR_W  = 13,
    parameter int          SN_BYTES = 8,
    parameter logic [15:0] DEV_ID  = 16'hC35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              arr_wr_req,
    output logic              arr_wr_en,
    input  logic              nv_store,
    input  logic              nv_recall,
    input  logic              nv_lock_in,
    output logic              nv_lock_snap
);
    localparam int ID_BASE = SN_BASE + SN_BYTES;

    prot_lvl_e               prot_q;
    logic                    lock;
    logic                    ctrl_wr;
    logic [SN_BYTES-1:0][7:0] sn_bytes;

    assign ctrl_wr = reg_we && (int'(reg_addr) == CTRL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prot_q <= PROT_NONE;
        else if (ctrl_wr) prot_q <= prot_lvl_e'(reg_wdata[PROT_LO_BIT +: 2]);
    end

    pmreg_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (ctrl_wr && reg_wdata[LOCK_BIT]),
        .store      (nv_store),
        .recall     (nv_recall),
        .recall_val (nv_lock_in),
        .lock_o     (lock),
        .snap_o     (nv_lock_snap)
    );

    pmreg_serial #(.N_BYTES(SN_BYTES)) u_sn (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .we      (reg_we),
        .locked  (lock),
        .bytes_o (sn_bytes)
    );

    pmreg_prot #(.ADDR_W(ADDR_W)) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (prot_q),
        .addr   (arr_addr),
        .wr_req (arr_wr_req),
        .wr_en  (arr_wr_en)
    );

    always_comb begin
        int a;
        a = int'(reg_addr);
        reg_rdata = 8'h00;
        if (a == CTRL_ADDR) begin
            reg_rdata[LOCK_BIT]          = lock;
            reg_rdata[PROT_LO_BIT +: 2]  = prot_q;
        end
        for (int i = 0; i < SN_BYTES; i++)
            if (a == SN_BASE + i) reg_rdata = sn_bytes[i];
        if (a == ID_BASE)     reg_rdata = DEV_ID[15:8];
        if (a == ID_BASE + 1) reg_rdata = DEV_ID[7:0];
    end

    // R1: bits outside the lock and protection fields of the control byte read 0
    a_r1_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) == CTRL_ADDR) |-> ((reg_rdata & 8'hB3) == 8'h00));

endmodule

// File: tb/sim_pmreg_bank.sv
`timescale 1ns/1ps
module sim_pmreg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [12:0] arr_addr = '0;
    logic        arr_wr_req = 1'b0;
    logic        arr_wr_en;
    logic        nv_store = 1'b0, nv_recall = 1'b0, nv_lock_in = 1'b0;
    logic        nv_lock_snap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmreg_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .arr_addr(arr_addr), .arr_wr_req(arr_wr_req), .arr_wr_en(arr_wr_en),
        .nv_store(nv_store), .nv_recall(nv_recall), .nv_lock_in(nv_lock_in),
        .nv_lock_snap(nv_lock_snap)
    );

    typedef struct packed {
        logic [1:0]  lvl;
        logic [12:0] addr;
        logic        req;
        logic        exp_en;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 13'h1FFF, 1'b1, 1'b1},
        '{2'd0, 13'h0000, 1'b1, 1'b1},
        '{2'd1, 13'h17FF, 1'b1, 1'b1},
        '{2'd1, 13'h1800, 1'b1, 1'b0},
        '{2'd1, 13'h1FFF, 1'b1, 1'b0},
        '{2'd2, 13'h0FFF, 1'b1, 1'b1},
        '{2'd2, 13'h1000, 1'b1, 1'b0},
        '{2'd2, 13'h17FF, 1'b1, 1'b0},
        '{2'd3, 13'h0000, 1'b1, 1'b0},
        '{2'd3, 13'h0FFF, 1'b1, 1'b0},
        '{2'd0, 13'h0800, 1'b0, 1'b0},
        '{2'd2, 13'h0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_store();
        @(negedge clk); nv_store = 1'b1;
        @(negedge clk); nv_store = 1'b0;
    endtask

    task automatic power_cycle(input logic restore);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nv_lock_in = restore; nv_recall = 1'b1;
        @(negedge clk); nv_recall = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        logic       saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        rd(8'h00, r); check("R3 ctrl", r, 8'h00);
        rd(8'h03, r); check("R3 serial", r, 8'h00);
        check("R3 snap", {7'd0, nv_lock_snap}, 8'h00);

        // R1 layout: write every bit except the lock
        wr(8'h00, 8'hBF); rd(8'h00, r); check("R1 ctrl readback", r, 8'h0C);

        // R2 protection table
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, {4'h0, VECS[i].lvl, 2'b00});
            @(negedge clk);
            arr_addr = VECS[i].addr; arr_wr_req = VECS[i].req;
            #1 check($sformatf("R2 vec%0d", i), {7'd0, arr_wr_en}, {7'd0, VECS[i].exp_en});
        end
        arr_wr_req = 1'b0;
        wr(8'h00, 8'h00);

        // R5 serial bytes writable while unlocked
        for (int i = 1; i <= 8; i++) wr(8'(i), 8'(i * 17));
        for (int i = 1; i <= 8; i++) begin
            rd(8'(i), r); check("R5 serial write", r, 8'(i * 17));
        end

        // R6 identity bytes, writes ignored
        wr(8'h09, 8'h00); wr(8'h0A, 8'hFF);
        rd(8'h09, r); check("R6 id high", r, 8'hC3);
        rd(8'h0A, r); check("R6 id low", r, 8'h5A);

        // R7 reserved and unmapped
        wr(8'h0B, 8'h77); wr(8'hAA, 8'h3C);
        rd(8'h0B, r); check("R7 reserved", r, 8'h00);
        rd(8'h0D, r); check("R7 reserved top", r, 8'h00);
        rd(8'hAA, r); check("R7 unmapped", r, 8'h00);
        rd(8'h00, r); check("R7 ctrl untouched", r, 8'h00);
        rd(8'h01, r); check("R7 serial untouched", r, 8'h11);

        // R8 store while open, then lock without store and lose it
        pulse_store();
        check("R8 snap open", {7'd0, nv_lock_snap}, 8'h00);
        wr(8'h00, 8'h40); rd(8'h00, r); check("R4 lock set", r, 8'h40);
        saved = nv_lock_snap;
        power_cycle(saved);
        rd(8'h00, r); check("R8 lock lost without store", r, 8'h00);

        // lock again, store under full protection
        wr(8'h05, 8'hA5);
        wr(8'h00, 8'h4C);
        pulse_store();
        check("R8 snap after lock", {7'd0, nv_lock_snap}, 8'h01);
        wr(8'h00, 8'h04); rd(8'h00, r); check("R4 clear ignored", r, 8'h44);
        wr(8'h05, 8'h00); rd(8'h05, r); check("R5 locked serial", r, 8'hA5);
        saved = nv_lock_snap;
        power_cycle(saved);
        rd(8'h00, r); check("R9 lock restored", r, 8'h40);

        // R9 recall beats store in the same cycle
        @(negedge clk); nv_recall = 1'b1; nv_lock_in = 1'b0; nv_store = 1'b1;
        @(negedge clk); nv_recall = 1'b0; nv_store = 1'b0;
        rd(8'h00, r); check("R9 recall clears", r, 8'h00);
        check("R9 store suppressed", {7'd0, nv_lock_snap}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule